// File: doc/BRIEF.md
# I2C Target Transmit Path with Clock Stretching

This block is the byte-sending half of an I2C target. A host queues a byte in a one-entry data holding register; the block moves it into an 8-bit shifter at each byte boundary and drives it MSB-first onto SDA. It pulls SDA low only for zero bits and leaves the line to the pull-up for ones. The bus controller generates the SCL pulses, which the block sees through a two-flop synchronizer. A byte boundary is the falling edge that ends an acknowledge clock, or a start pulse from the address logic outside this block.

If the holding register is empty at a byte boundary, the block holds SCL low until the host supplies a byte. It then places the first bit on SDA and keeps SCL low for a programmable number of extra clocks, which sets the data setup time. A NACK from the receiver ends the transfer without loading or stretching.

Dropping the enable input is a software reset. Both lines are released at once, and the transfer state and flags return to their reset values. The setup-count configuration keeps its value through this reset.

Top module: `i2c_tx_path`

## Requirements
- R1: After hardware reset, scl_oe=0, sda_oe=0, tx_empty=1, nack_flag=0 and busy=0.
- R2: A write to the data register (wr_data=1 while en=1) gives tx_empty=0 on the next cycle. Moving the byte into the shifter sets tx_empty=1. A data write while en=0 is ignored, so tx_empty stays 1.
- R3: Bits leave MSB-first. sda_oe=1 exactly when the current bit is 0. The bit on SDA changes only after a synchronized falling edge of SCL, never while SCL is high.
- R4: At a byte boundary with tx_empty=0, the queued byte is loaded and its MSB is driven with no stretch (scl_oe stays 0).
- R5: At a byte boundary with tx_empty=1, scl_oe goes to 1 and stays 1 until a data write. scl_oe is never 1 during data bits 2 to 8 or the acknowledge clock.
- R6: After a data write ends a stretch, the first bit is on SDA while SCL is still held. scl_oe stays 1 for cfg_setup+2 cycles after the write edge, and sda_oe is valid during the last cfg_setup+1 of those cycles.
- R7: During the acknowledge clock, sda_oe=0. If SDA is sampled high at that SCL rise, nack_flag becomes 1 and the block returns to idle (busy=0) without stretching.
- R8: When en falls, scl_oe and sda_oe drop in the same cycle. One cycle later tx_empty=1, nack_flag=0 and busy=0.
- R9: The setup count written through wr_cfg is kept through a software reset.
- R10: A tx_go pulse while idle clears nack_flag and starts a byte boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| en | input | 1 | Peripheral enable; low means software reset |
| wr_data | input | 1 | Write strobe for the data holding register |
| wdata | input | DATA_W | Byte written to the holding register |
| wr_cfg | input | 1 | Write strobe for the setup-count configuration |
| cfg_setup_wdata | input | SETUP_W | New setup count in clock cycles |
| tx_go | input | 1 | Start of a read transfer (SCL already low) |
| scl_in | input | 1 | SCL line level, asynchronous |
| sda_in | input | 1 | SDA line level, asynchronous |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| tx_empty | output | 1 | Holding register empty |
| nack_flag | output | 1 | Receiver answered NACK |
| busy | output | 1 | A transfer is in progress |

## Verification
The bench models a bus controller that waits on the wired SCL line. It checks every bit it samples before each rise. It checks for a mid-byte stretch, which a design that tested the empty flag at the wrong edge would produce. It also checks for a missing stretch, which would let garbage bits onto the bus. The release after a write is counted cycle by cycle: a design that let SCL go too early, or before the first bit was driven, shows the wrong count. A NACK must stop the transfer, since a design that still stretched would hang the bus. A software reset taken mid-stretch must release SCL at once and keep the setup count; a design that cleared that count would shorten the next release.

// File: rtl/i2ctx_pkg.sv
package i2ctx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BIT,
        ST_ACK,
        ST_HOLD,
        ST_SETUP
    } tx_state_e;
endpackage

// File: rtl/i2ctx_sync.sv
module i2ctx_sync #(
    parameter int          WIDTH  = 2,
    parameter int          STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/i2ctx_cfg.sv
module i2ctx_cfg #(
    parameter int SETUP_W   = 8,
    parameter int SETUP_RST = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_cfg,
    input  logic [SETUP_W-1:0] cfg_setup_wdata,
    output logic [SETUP_W-1:0] setup_cnt
);
    logic [SETUP_W-1:0] setup_d, setup_q;

    always_comb begin
        setup_d = setup_q;
        if (wr_cfg) setup_d = cfg_setup_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) setup_q <= SETUP_W'(SETUP_RST);
        else        setup_q <= setup_d;
    end

    assign setup_cnt = setup_q;
endmodule

// File: rtl/i2ctx_core.sv
module i2ctx_core
    import i2ctx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int SETUP_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               wr_data,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               tx_go,
    input  logic               scl_s,
    input  logic               sda_s,
    input  logic [SETUP_W-1:0] setup_cnt,
    output logic               scl_oe,
    output logic               sda_oe,
    output logic               tx_empty,
    output logic               nack_flag,
    output logic               busy
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    typedef struct packed {
        tx_state_e          st;
        logic [DATA_W-1:0]  shf;
        logic [DATA_W-1:0]  dat;
        logic [IDX_W-1:0]   bidx;
        logic [SETUP_W-1:0] cnt;
        logic               empty;
        logic               nack;
        logic               ackbit;
        logic               scl_prev;
    } core_s;

    localparam core_s CORE_RST = '{
        st:       ST_IDLE,
        shf:      '0,
        dat:      '0,
        bidx:     '0,
        cnt:      '0,
        empty:    1'b1,
        nack:     1'b0,
        ackbit:   1'b0,
        scl_prev: 1'b1
    };

    core_s q, d;
    logic  scl_fall, scl_rise, boundary;

    always_comb begin
        d        = q;
        scl_fall = q.scl_prev & ~scl_s;
        scl_rise = ~q.scl_prev & scl_s;
        boundary = 1'b0;

        if (!en) begin
            d = CORE_RST;
        end else begin
            case (q.st)
                ST_IDLE: begin
                    if (tx_go) begin
                        d.nack   = 1'b0;
                        boundary = 1'b1;
                    end
                end
                ST_BIT: begin
                    if (scl_fall) begin
                        if (q.bidx == LAST_IDX) begin
                            d.st   = ST_ACK;
                            d.bidx = '0;
                        end else begin
                            d.shf  = {q.shf[DATA_W-2:0], 1'b0};
                            d.bidx = q.bidx + 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_rise) d.ackbit = sda_s;
                    if (scl_fall) begin
                        if (q.ackbit) begin
                            d.nack = 1'b1;
                            d.st   = ST_IDLE;
                        end else begin
                            boundary = 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (!q.empty) begin
                        d.shf   = q.dat;
                        d.empty = 1'b1;
                        d.cnt   = setup_cnt;
                        d.st    = ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (q.cnt == '0) d.st  = ST_BIT;
                    else             d.cnt = q.cnt - 1'b1;
                end
                default: d.st = ST_IDLE;
            endcase

            if (boundary) begin
                d.bidx = '0;
                if (!q.empty) begin
                    d.shf   = q.dat;
                    d.empty = 1'b1;
                    d.st    = ST_BIT;
                end else begin
                    d.st    = ST_HOLD;
                end
            end

            if (wr_data) begin
                d.dat   = wdata;
                d.empty = 1'b0;
            end
        end
        d.scl_prev = scl_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CORE_RST;
        else        q <= d;
    end

    assign scl_oe    = en & ((q.st == ST_HOLD) | (q.st == ST_SETUP));
    assign sda_oe    = en & ((q.st == ST_BIT) | (q.st == ST_SETUP)) & ~q.shf[DATA_W-1];
    assign tx_empty  = q.empty;
    assign nack_flag = q.nack;
    assign busy      = (q.st != ST_IDLE);
endmodule

// File: rtl/i2c_tx_path.sv
module i2c_tx_path #(
    parameter int DATA_W      = 8,
    parameter int SETUP_W     = 8,
    parameter int SETUP_RST   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               wr_data,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               wr_cfg,
    input  logic [SETUP_W-1:0] cfg_setup_wdata,
    input  logic               tx_go,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               scl_oe,
    output logic               sda_oe,
    output logic               tx_empty,
    output logic               nack_flag,
    output logic               busy
);
    logic [1:0]         line_s;
    logic [SETUP_W-1:0] setup_cnt;

    i2ctx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     (line_s)
    );

    i2ctx_cfg #(.SETUP_W(SETUP_W), .SETUP_RST(SETUP_RST)) u_cfg (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_cfg          (wr_cfg),
        .cfg_setup_wdata (cfg_setup_wdata),
        .setup_cnt       (setup_cnt)
    );

    i2ctx_core #(.DATA_W(DATA_W), .SETUP_W(SETUP_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .wr_data   (wr_data),
        .wdata     (wdata),
        .tx_go     (tx_go),
        .scl_s     (line_s[1]),
        .sda_s     (line_s[0]),
        .setup_cnt (setup_cnt),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .tx_empty  (tx_empty),
        .nack_flag (nack_flag),
        .busy      (busy)
    );
endmodule

// File: rtl/i2ctx_chk.sv
module i2ctx_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic wr_data,
    input logic scl_in,
    input logic scl_oe,
    input logic sda_oe,
    input logic tx_empty,
    input logic nack_flag,
    input logic busy
);
    // R2: a host write always leaves the register full on the next cycle
    p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_data) |=> !tx_empty);

    // R3: SDA drive stays put while SCL has been high long enough to be seen
    p_sda_stable_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_in && $past(scl_in) && $past(scl_in, 2) && $past(scl_in, 3)
         && $past(scl_in, 4) && en && $past(en)) |-> $stable(sda_oe));

    // R5: a stretch can only start while the register is empty
    p_stretch_only_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> tx_empty);

    // R6: once a byte is pending during a stretch, SCL is still held next cycle
    p_hold_until_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && !tx_empty && en) |=> (scl_oe || !en));

    // R7: a NACK leaves the block idle
    p_nack_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack_flag) |-> !busy);

    // R8: software reset restores flags one cycle after enable falls
    p_swreset_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |=> (tx_empty && !nack_flag && !busy));

    // R8: disabled block never pulls a line
    p_swreset_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !$past(en)) |-> (!scl_oe && !sda_oe));
endmodule

bind i2c_tx_path i2ctx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .wr_data   (wr_data),
    .scl_in    (scl_in),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .tx_empty  (tx_empty),
    .nack_flag (nack_flag),
    .busy      (busy)
);

// File: tb/sim_i2c_tx_path.sv
`timescale 1ns/1ps
module sim_i2c_tx_path;
    localparam int LOW_T  = 12;
    localparam int HIGH_T = 10;
    localparam int SETUP  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       wr_data = 1'b0;
    logic [7:0] wdata = '0;
    logic       wr_cfg = 1'b0;
    logic [7:0] cfg_setup_wdata = '0;
    logic       tx_go = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       scl_oe, sda_oe, tx_empty, nack_flag, busy;
    logic       scl_line, sda_line;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    i2c_tx_path u0 (
        .clk (clk), .rst_n (rst_n), .en (en),
        .wr_data (wr_data), .wdata (wdata),
        .wr_cfg (wr_cfg), .cfg_setup_wdata (cfg_setup_wdata),
        .tx_go (tx_go), .scl_in (scl_line), .sda_in (sda_line),
        .scl_oe (scl_oe), .sda_oe (sda_oe), .tx_empty (tx_empty),
        .nack_flag (nack_flag), .busy (busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] v);
        @(negedge clk); wr_data = 1'b1; wdata = v;
        @(negedge clk); wr_data = 1'b0;
    endtask

    task automatic pulse_go();
        @(negedge clk); tx_go = 1'b1;
        @(negedge clk); tx_go = 1'b0;
    endtask

    // Clocks one byte plus acknowledge; returns with SCL low after the 9th pulse.
    task automatic read_byte(input logic [7:0] exp, input bit give_nack,
                             input logic [7:0] mid_write, input bit do_mid);
        int stretch_seen = 0;
        for (int b = 7; b >= 0; b--) begin
            for (int i = 0; i < LOW_T; i++) begin
                @(negedge clk);
                if (b != 7 && scl_oe) stretch_seen++;
            end
            check(sda_line == exp[b], "R3 bit value", sda_line, exp[b]);
            scl_m = 1'b1;
            for (int i = 0; i < HIGH_T; i++) begin
                @(negedge clk);
                if (scl_oe) stretch_seen++;
            end
            scl_m = 1'b0;
            if (b == 4 && do_mid) begin
                host_write(mid_write);
                check(tx_empty == 1'b0, "R2 write clears empty", tx_empty, 0);
            end
        end
        for (int i = 0; i < LOW_T; i++) begin
            @(negedge clk);
            if (scl_oe) stretch_seen++;
            if (i == 3) sda_m = give_nack;
        end
        check(sda_oe == 1'b0, "R7 SDA released on ack clock", sda_oe, 0);
        scl_m = 1'b1;
        for (int i = 0; i < HIGH_T; i++) begin
            @(negedge clk);
            if (scl_oe) stretch_seen++;
        end
        scl_m = 1'b0;
        @(negedge clk);
        sda_m = 1'b1;
        check(stretch_seen == 0, "R5 no stretch inside byte", stretch_seen, 0);
    endtask

    // Write during a stretch and count the release timing.
    task automatic measure_setup(input logic [7:0] v, input int setup, input string req);
        int held = 0;
        int both = 0;
        host_write(v);
        held = 1;
        if (scl_oe && sda_oe) both++;
        for (int i = 0; i < 100 && scl_oe; i++) begin
            @(negedge clk);
            if (scl_oe) held++;
            if (scl_oe && sda_oe) both++;
        end
        check(held == setup + 2, {req, " SCL hold after write"}, held, setup + 2);
        check(both == setup + 1, {req, " data valid before release"}, both, setup + 1);
        check(tx_empty == 1'b1, "R2 load sets empty", tx_empty, 1);
    endtask

    task automatic t_reset();
        wait_cyc(2);
        check(scl_oe == 0,   "R1 scl_oe", scl_oe, 0);
        check(sda_oe == 0,   "R1 sda_oe", sda_oe, 0);
        check(tx_empty == 1, "R1 tx_empty", tx_empty, 1);
        check(nack_flag == 0, "R1 nack_flag", nack_flag, 0);
        check(busy == 0,     "R1 busy", busy, 0);
    endtask

    task automatic t_write_disabled();
        host_write(8'h77);
        wait_cyc(1);
        check(tx_empty == 1, "R2 write ignored while disabled", tx_empty, 1);
        @(negedge clk); en = 1'b1;
        wait_cyc(1);
        check(tx_empty == 1, "R2 still empty after enable", tx_empty, 1);
    endtask

    task automatic t_chain();
        @(negedge clk); wr_cfg = 1'b1; cfg_setup_wdata = SETUP;
        @(negedge clk); wr_cfg = 1'b0;
        host_write(8'hA5);
        scl_m = 1'b0;
        wait_cyc(4);
        pulse_go();
        check(busy == 1, "R10 go starts transfer", busy, 1);
        check(scl_oe == 0, "R4 queued byte no stretch", scl_oe, 0);
        read_byte(8'hA5, 1'b0, 8'h3C, 1'b1);
        wait_cyc(4);
        check(scl_oe == 0, "R4 boundary with queued byte", scl_oe, 0);
        read_byte(8'h3C, 1'b0, 8'h00, 1'b0);
        wait_cyc(5);
        check(scl_oe == 1, "R5 stretch when empty", scl_oe, 1);
        wait_cyc(20);
        check(scl_oe == 1, "R5 stretch held", scl_oe, 1);
        measure_setup(8'h12, SETUP, "R6");
        read_byte(8'h12, 1'b1, 8'h00, 1'b0);
        wait_cyc(6);
        check(nack_flag == 1, "R7 nack flag", nack_flag, 1);
        check(busy == 0, "R7 idle after nack", busy, 0);
        wait_cyc(20);
        check(scl_oe == 0, "R7 no stretch after nack", scl_oe, 0);
    endtask

    task automatic t_swreset();
        pulse_go();
        check(nack_flag == 0, "R10 go clears nack", nack_flag, 0);
        wait_cyc(2);
        check(scl_oe == 1, "R5 stretch on empty start", scl_oe, 1);
        @(negedge clk); en = 1'b0;
        #0.1;
        check(scl_oe == 0, "R8 SCL released at once", scl_oe, 0);
        check(sda_oe == 0, "R8 SDA released at once", sda_oe, 0);
        @(negedge clk);
        check(busy == 0, "R8 busy cleared", busy, 0);
        check(tx_empty == 1, "R8 empty restored", tx_empty, 1);
        wait_cyc(3);
        @(negedge clk); en = 1'b1;
        pulse_go();
        wait_cyc(2);
        check(scl_oe == 1, "R9 stretch after reset", scl_oe, 1);
        measure_setup(8'h40, SETUP, "R9");
        @(negedge clk); en = 1'b0;
        wait_cyc(2);
        en = 1'b1;
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_write_disabled();
        t_chain();
        t_swreset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule